// File: doc/BRIEF.md
# Single-Wire Echoing Monitor Serial Port

This block is a half-duplex debug port that talks to a host over one shared wire. Characters arrive as NRZ mark/space frames: a low start bit, eight data bits with the least significant first, and a high stop bit. Each byte that is framed correctly is sent straight back on the same wire as an echo. The host can compare each echo against what it sent to catch errors. The block drives the wire only while it transmits. At all other times it releases the wire, and the wire idles high.

A break is a line held low for the start bit and nine more bit periods, so the stop position is also low. The block answers a break in two steps. First it drives the wire high for two bit periods. Then it sends a character whose data is all zeros.

The block also decodes one command: a read opcode, then an address high byte, then an address low byte. When the low address byte arrives, the block issues a single-cycle request on a synchronous memory read port. It takes the returned byte in the cycle after the request. That byte goes out on the wire only after the echo of the low address byte has finished. Any other opcode is echoed and then dropped.

Timing comes from a `tick` input. This input pulses `TICKS_PER_BIT` times per bit period, at a bit rate of up to 28.8 kBaud, and the same rate is used for receive and transmit.

Top module: `echo_mon_port`

## Requirements
- R1: A byte received with a high stop bit is echoed as low start, the same eight data bits least significant first, and high stop, one bit period each. The echo starts within the received stop bit.
- R2: Whenever `pin_oe` is low, `pin_out` is high. After reset, `pin_oe` and `mem_req` are low.
- R3: A low pulse shorter than half a bit period is not taken as a start bit and produces no transmission.
- R4: After a break ends (line back high), `pin_out` is driven high for exactly two bit periods, then a low start bit, eight zero data bits and a high stop bit follow.
- R5: A frame whose stop bit is low and whose data is nonzero is discarded, and no echo is sent.
- R6: After the sequence read opcode (parameter `READ_OP`, default 8'h4A), address high, address low, the memory byte at that address is sent as a character. This happens after the echo of the address low byte and is separated from that echo by at least one cycle with `pin_oe` low.
- R7: A first command byte other than `READ_OP` is echoed, causes no memory request, and leaves the parser idle.
- R8: A break returns the command parser to idle, so a read opcode received before the break is forgotten.
- R9: Each read issues exactly one cycle of `mem_req`, with `mem_addr` equal to {address high, address low}. The data on `mem_rdata` is taken in the following cycle.
- R10: While `pin_oe` is high, the receiver does not start a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing pulse, `TICKS_PER_BIT` per bit period |
| pin_in | input | 1 | Level sensed on the shared wire |
| pin_out | output | 1 | Level driven onto the wire when enabled |
| pin_oe | output | 1 | Drive enable for the wire |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | 16 | Read address, valid with `mem_req` |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_req` |

## Verification
The memory fetch and the echo of the address low byte start on the same clock edge: the request is raised on the edge that loads the echo into the transmit register. The data then arrives while that echo is still on the wire. The bench provokes this with back-to-back reads, including one where every byte equals the opcode. It judges the outcome by the order of frames in its scoreboard queue, which requires the echo to be complete before the result appears. It also checks that exactly one request cycle, carrying the right address, is seen per read.

// File: rtl/echo_mon_port.sv
module echo_mon_port #(
  parameter int         TICKS_PER_BIT = 8,
  parameter logic [7:0] READ_OP       = 8'h4A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        pin_in,
  output logic        pin_out,
  output logic        pin_oe,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata
);

  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam logic [TW-1:0] T_LAST = TW'(TICKS_PER_BIT - 1);
  localparam logic [TW-1:0] T_MID  = TW'(TICKS_PER_BIT / 2 - 1);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_WAIT} rx_e;

  rx_e           rx_st;
  logic [TW-1:0] rx_t;
  logic [2:0]    rx_n;
  logic [7:0]    rx_sh;
  logic          brk_seen;

  logic [1:0]    cmd;
  logic [7:0]    a_hi;
  logic          req_d;
  logic [7:0]    res;
  logic          res_pend;

  logic [11:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [TW-1:0] tx_t;

  wire tx_busy = tx_left != 4'd0;
  wire rx_byte = rx_st == R_STOP && tick && rx_t == T_LAST && pin_in;
  wire rx_brk  = rx_st == R_WAIT && pin_in && brk_seen;
  wire res_go  = res_pend && !tx_busy && !rx_byte && !rx_brk;

  assign pin_oe  = tx_busy;
  assign pin_out = !tx_busy || tx_sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st    <= R_IDLE;
      rx_t     <= '0;
      rx_n     <= '0;
      rx_sh    <= '0;
      brk_seen <= 1'b0;
    end else begin
      case (rx_st)
        R_IDLE:
          if (tick && !pin_oe && !pin_in) begin
            rx_st <= R_START;
            rx_t  <= '0;
          end
        R_START:
          if (tick) begin
            if (rx_t == T_MID) begin
              rx_t  <= '0;
              rx_n  <= '0;
              rx_st <= pin_in ? R_IDLE : R_DATA;
            end else rx_t <= rx_t + 1'b1;
          end
        R_DATA:
          if (tick) begin
            if (rx_t == T_LAST) begin
              rx_t  <= '0;
              rx_sh <= {pin_in, rx_sh[7:1]};
              rx_n  <= rx_n + 3'd1;
              if (rx_n == 3'd7) rx_st <= R_STOP;
            end else rx_t <= rx_t + 1'b1;
          end
        R_STOP:
          if (tick) begin
            if (rx_t == T_LAST) begin
              rx_t     <= '0;
              brk_seen <= rx_sh == 8'h00;
              rx_st    <= pin_in ? R_IDLE : R_WAIT;
            end else rx_t <= rx_t + 1'b1;
          end
        R_WAIT:
          if (pin_in) rx_st <= R_IDLE;
        default: rx_st <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= 2'd0;
      a_hi     <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      req_d    <= 1'b0;
      res      <= '0;
      res_pend <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      req_d   <= mem_req;
      if (rx_brk) cmd <= 2'd0;
      else if (rx_byte) begin
        case (cmd)
          2'd0: if (rx_sh == READ_OP) cmd <= 2'd1;
          2'd1: begin a_hi <= rx_sh; cmd <= 2'd2; end
          default: begin
            cmd      <= 2'd0;
            mem_req  <= 1'b1;
            mem_addr <= {a_hi, rx_sh};
          end
        endcase
      end
      if (req_d) begin
        res      <= mem_rdata;
        res_pend <= 1'b1;
      end else if (res_go) res_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '1;
      tx_left <= '0;
      tx_t    <= '0;
    end else if (rx_byte) begin
      tx_sh   <= {3'b111, rx_sh, 1'b0};
      tx_left <= 4'd10;
      tx_t    <= '0;
    end else if (rx_brk) begin
      tx_sh   <= {1'b1, 8'h00, 1'b0, 2'b11};
      tx_left <= 4'd12;
      tx_t    <= '0;
    end else if (res_go) begin
      tx_sh   <= {3'b111, res, 1'b0};
      tx_left <= 4'd10;
      tx_t    <= '0;
    end else if (tx_busy && tick) begin
      if (tx_t == T_LAST) begin
        tx_t    <= '0;
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
      end else tx_t <= tx_t + 1'b1;
    end
  end

endmodule

// File: rtl/echo_mon_port_chk.sv
module echo_mon_port_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_out,
  input logic pin_oe,
  input logic mem_req
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> pin_out);

  assert_stop_before_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_oe) |-> $past(pin_out));

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_req_during_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> pin_oe);

endmodule

bind echo_mon_port echo_mon_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_oe(pin_oe), .mem_req(mem_req)
);

// File: tb/tb_echo_mon_port.sv
module tb_echo_mon_port;
  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 8;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLK    = TPB * TICK_DIV;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, host_drv = 1'b1;
  logic pin_out, pin_oe, mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_arr [256];
  wire pin_in = pin_oe ? pin_out : host_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV-1);
  end

  always @(posedge clk) if (mem_req) mem_rdata <= mem_arr[mem_addr[7:0]];

  echo_mon_port #(.TICKS_PER_BIT(TPB), .READ_OP(8'h4A)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  typedef struct { logic [11:0] bits; int len; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0, frames = 0, req_cnt = 0;
  logic [15:0] last_addr = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) if (mem_req === 1'b1) begin
    req_cnt++;
    last_addr = mem_addr;
  end

  initial begin : mon
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (pin_oe && !prev) begin
        item_t it;
        logic [11:0] got, m;
        int hi_len, last_k;
        frames++;
        if (exp_q.size() == 0) check(0, "R1", "unexpected frame", frames, 0);
        else begin
          it = exp_q.pop_front();
          got = '1;
          hi_len = -1;
          last_k = (it.len-1)*BIT_CLK + BIT_CLK/2;
          for (int k = 0; k <= last_k; k++) begin
            if (hi_len < 0 && !pin_out) hi_len = k;
            if (k % BIT_CLK == BIT_CLK/2) got[k/BIT_CLK] = pin_out;
            if (k != last_k) @(negedge clk);
          end
          m = 12'hFFF >> (12 - it.len);
          check((got & m) == (it.bits & m), it.tag, "frame bits", int'(got & m), int'(it.bits & m));
          if (it.len == 12)
            check(hi_len >= 2*BIT_CLK-1 && hi_len <= 2*BIT_CLK, "R4", "break high hold clocks",
                  hi_len, 2*BIT_CLK);
        end
        prev = 1'b1;
      end else prev = pin_oe;
    end
  end

  task automatic push_char(input logic [7:0] d, input string tag);
    item_t it;
    it.bits = {3'b111, d, 1'b0};
    it.len = 10;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic stop);
    @(negedge clk);
    host_drv = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      host_drv = d[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    host_drv = stop;
    repeat (BIT_CLK) @(negedge clk);
    host_drv = 1'b1;
  endtask

  task automatic wait_quiet();
    int q;
    while (exp_q.size() != 0) @(negedge clk);
    q = 0;
    while (q < 3*BIT_CLK) begin
      @(negedge clk);
      if (pin_oe) q = 0; else q++;
    end
  endtask

  task automatic send(input logic [7:0] d, input string tag);
    push_char(d, tag);
    drive_frame(d, 1'b1);
    wait_quiet();
  endtask

  task automatic send_break();
    item_t it;
    it.bits = {1'b1, 8'h00, 1'b0, 2'b11};
    it.len = 12;
    it.tag = "R4";
    exp_q.push_back(it);
    @(negedge clk);
    host_drv = 1'b0;
    repeat (10*BIT_CLK) @(negedge clk);
    host_drv = 1'b1;
    wait_quiet();
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    int rc;
    rc = req_cnt;
    send(8'h4A, tag);
    send(a[15:8], tag);
    push_char(a[7:0], tag);
    push_char(mem_arr[a[7:0]], "R6");
    drive_frame(a[7:0], 1'b1);
    wait_quiet();
    check(req_cnt == rc + 1, "R9", "request cycles per read", req_cnt - rc, 1);
    check(last_addr == a, "R9", "request address", int'(last_addr), int'(a));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int f0, rc;
    for (int i = 0; i < 256; i++) mem_arr[i] = 8'(i*37 + 11);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pin_oe == 1'b0, "R2", "oe after reset", int'(pin_oe), 0);
    check(pin_out == 1'b1, "R2", "out after reset", int'(pin_out), 1);
    check(mem_req == 1'b0, "R2", "req after reset", int'(mem_req), 0);

    send(8'hA5, "R1");
    send(8'h00, "R1");
    send(8'hFF, "R1");
    send(8'h01, "R1");
    send(8'h80, "R1");
    check(pin_oe == 1'b0 && pin_out == 1'b1, "R2", "idle level between chars", int'(pin_out), 1);

    f0 = frames;
    @(negedge clk);
    host_drv = 1'b0;
    repeat (3) @(negedge clk);
    host_drv = 1'b1;
    wait_quiet();
    check(frames == f0, "R3", "frames after short glitch", frames - f0, 0);

    f0 = frames;
    drive_frame(8'h55, 1'b0);
    wait_quiet();
    check(frames == f0, "R5", "frames after bad stop", frames - f0, 0);

    send_break();

    rc = req_cnt;
    send(8'h11, "R7");
    send(8'h22, "R7");
    send(8'h34, "R7");
    check(req_cnt == rc, "R7", "requests after unknown opcode", req_cnt - rc, 0);

    do_read(16'h1234, "R6");
    do_read(16'hBEEF, "R6");
    do_read(16'h4A4A, "R6");

    send(8'h4A, "R8");
    send_break();
    do_read(16'h0005, "R8");

    f0 = frames;
    push_char(8'h3C, "R10");
    drive_frame(8'h3C, 1'b1);
    repeat (2*BIT_CLK) @(negedge clk);
    host_drv = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    host_drv = 1'b1;
    wait_quiet();
    check(frames == f0 + 1, "R10", "frames with low pulse during echo", frames - f0, 1);

    check(exp_q.size() == 0, "R1", "leftover expected frames", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule